// File: doc/BRIEF.md
# Multiplexed Register Transfer Unit

This block holds a bank of equal-width registers that share one transfer path. On any cycle one register may be copied into another: a source index picks which register's contents appear on an internal shared bus, and a destination index, gated by a transfer strobe, picks the one register that captures that bus value on the next rising clock edge. Every bit position has its own multiplexer, and all of them are steered by the same source index.

Loading is done with synchronous load enables on one common clock, with no clock gating. A separate write port can place an outside value into any register, for example to preload the bank before a run of transfers. It is a plain strobe that is accepted on every cycle, so it has no back-pressure. The present contents of every register are visible on one flat output vector. A synchronous reset clears the bank.

Top module: `reg_xfer_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every register becomes zero after that edge. Reset takes priority over transfers and writes.
- R2: With `xfer_en` high at an edge, register `dst_sel` afterwards holds the value that register `src_sel` held before that edge. All W bits are copied. Register k occupies bits `regs_o[k*W +: W]`, with its bit 0 at the lowest position.
- R3: At most one register is loaded from the shared bus per edge. Every register that is neither the transfer destination nor the write target keeps its value.
- R4: The source register of a transfer keeps its value, unless it is also the write target.
- R5: With `xfer_en` low, the destination decoder asserts no load line. Changing `src_sel` or `dst_sel` then alters no register.
- R6: A transfer whose source and destination index are the same leaves that register unchanged.
- R7: With `wr_en` high at an edge, register `wr_sel` afterwards holds `wr_data`.
- R8: When the write target equals the transfer destination on the same edge, the register takes `wr_data`, not the bus value.
- R9: A write and a transfer to different registers on the same edge both take effect. The bus carries the source value from before the edge, even when the source is the write target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| xfer_en | input | 1 | Transfer strobe; enables the destination decoder |
| src_sel | input | SEL_W (3) | Index of the register driven onto the shared bus |
| dst_sel | input | SEL_W (3) | Index of the register that loads the bus value |
| wr_en | input | 1 | External write strobe |
| wr_sel | input | SEL_W (3) | Index of the register loaded by the write port |
| wr_data | input | W (8) | Value loaded by the write port |
| regs_o | output | NREG*W (64) | Contents of all registers, register k at `[k*W +: W]` |

## Verification
Transfers are tried with every register holding a distinct value, so a wrong source index or a wrong destination gives a visible mismatch, and a missing bit lane shows up as a partly copied value. Idle cycles that keep moving the selects while `xfer_en` is low, and same-index transfers, separate a decoder that honours its enable from one that does not. Same-edge collisions between the write port and a transfer, to the same register and to different registers, and a write into the current source, show write priority and whether the bus uses the value from before the edge. Long random runs of mixed transfers and writes are checked against a reference array after every edge. A reset applied in the middle of activity shows that reset wins.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
  // Per-register load choice resolved from the two decoders
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_BUS  = 2'd1,
    LD_EXT  = 2'd2
  } ld_src_e;
endpackage

// File: rtl/rtu_dst_decoder.sv
// Binary index to one-hot load lines, gated by an enable
module rtu_dst_decoder #(
  parameter int NREG  = 8,
  parameter int SEL_W = 3
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [NREG-1:0]  hot
);
  for (genvar i = 0; i < NREG; i++) begin : g_line
    assign hot[i] = en && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/rtu_src_mux.sv
// One NREG-to-1 multiplexer per bit lane, all sharing the source index
module rtu_src_mux #(
  parameter int NREG  = 8,
  parameter int W     = 8,
  parameter int SEL_W = 3
) (
  input  logic [NREG*W-1:0] regs_flat,
  input  logic [SEL_W-1:0]  sel,
  output logic [W-1:0]      bus
);
  for (genvar b = 0; b < W; b++) begin : g_lane
    logic [NREG-1:0] column;
    for (genvar r = 0; r < NREG; r++) begin : g_tap
      assign column[r] = regs_flat[r*W + b];
    end
    assign bus[b] = column[sel];
  end
endmodule

// File: rtl/rtu_reg_bank.sv
// Register bank with synchronous load enables on a single clock
module rtu_reg_bank
  import rtu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG-1:0]   bus_ld,
  input  logic [NREG-1:0]   ext_ld,
  input  logic [W-1:0]      bus,
  input  logic [W-1:0]      ext_data,
  output logic [NREG*W-1:0] regs_flat
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    ld_src_e      pick;
    logic [W-1:0] q;

    // The external write outranks the bus on the same register
    always_comb begin
      if (ext_ld[i])      pick = LD_EXT;
      else if (bus_ld[i]) pick = LD_BUS;
      else                pick = LD_NONE;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else begin
        case (pick)
          LD_EXT:  q <= ext_data;
          LD_BUS:  q <= bus;
          default: q <= q;
        endcase
      end
    end

    assign regs_flat[i*W +: W] = q;
  end
endmodule

// File: rtl/reg_xfer_unit.sv
// Top: shared-bus register transfer with decoded destination
module reg_xfer_unit #(
  parameter int  NREG  = 8,
  parameter int  W     = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_en,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic [SEL_W-1:0]  dst_sel,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [W-1:0]      wr_data,
  output logic [NREG*W-1:0] regs_o
);
  logic [W-1:0]    xfer_bus;
  logic [NREG-1:0] xfer_ld;
  logic [NREG-1:0] ext_ld;

  rtu_src_mux #(.NREG(NREG), .W(W), .SEL_W(SEL_W)) u_mux (
    .regs_flat (regs_o),
    .sel       (src_sel),
    .bus       (xfer_bus)
  );

  rtu_dst_decoder #(.NREG(NREG), .SEL_W(SEL_W)) u_dst_dec (
    .en  (xfer_en),
    .sel (dst_sel),
    .hot (xfer_ld)
  );

  rtu_dst_decoder #(.NREG(NREG), .SEL_W(SEL_W)) u_wr_dec (
    .en  (wr_en),
    .sel (wr_sel),
    .hot (ext_ld)
  );

  rtu_reg_bank #(.NREG(NREG), .W(W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .bus_ld    (xfer_ld),
    .ext_ld    (ext_ld),
    .bus       (xfer_bus),
    .ext_data  (wr_data),
    .regs_flat (regs_o)
  );
endmodule

// File: rtl/reg_xfer_unit_chk.sv
module reg_xfer_unit_chk #(
  parameter int NREG  = 8,
  parameter int W     = 8,
  parameter int SEL_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_en,
  input logic [SEL_W-1:0]  src_sel,
  input logic [SEL_W-1:0]  dst_sel,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [W-1:0]      wr_data,
  input logic [NREG*W-1:0] regs_o,
  input logic [NREG-1:0]   xfer_ld
);
  // Armed once a reset edge has been seen, so $past never reaches pre-reset values
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | rst;

  logic [W-1:0] src_val;
  logic [W-1:0] dst_val;
  assign src_val = regs_o[src_sel*W +: W];
  assign dst_val = regs_o[dst_sel*W +: W];

  logic [NREG-1:0] touch;
  for (genvar i = 0; i < NREG; i++) begin : g_touch
    assign touch[i] = (xfer_en && dst_sel == SEL_W'(i)) || (wr_en && wr_sel == SEL_W'(i));
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    armed && $past(rst) |-> regs_o == '0);

  // R2, R6: destination gets the pre-edge source value
  a_r2_xfer_lands: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(xfer_en) &&
    !($past(wr_en) && $past(wr_sel) == $past(dst_sel))
    |-> regs_o[$past(dst_sel)*W +: W] == $past(src_val));

  // R7, R8: write lands and wins over a same-register transfer
  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(wr_en)
    |-> regs_o[$past(wr_sel)*W +: W] == $past(wr_data));

  // R3: the transfer decoder raises at most one load line
  a_r3_single_load: assert property (@(posedge clk) disable iff (rst)
    $onehot0(xfer_ld));

  // R5: decoder silent while the transfer strobe is low
  a_r5_decode_idle: assert property (@(posedge clk) disable iff (rst)
    !xfer_en |-> xfer_ld == '0);

  // R3, R4: untouched registers (including the source) hold
  for (genvar i = 0; i < NREG; i++) begin : g_hold
    a_r3_others_hold: assert property (@(posedge clk) disable iff (rst)
      armed && !$past(rst) && !$past(touch[i])
      |-> $stable(regs_o[i*W +: W]));
  end

  // R6: a same-index transfer with no write leaves the register alone
  a_r6_self_xfer: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(xfer_en) && $past(src_sel) == $past(dst_sel) &&
    !($past(wr_en) && $past(wr_sel) == $past(dst_sel))
    |-> regs_o[$past(dst_sel)*W +: W] == $past(dst_val));
endmodule

bind reg_xfer_unit reg_xfer_unit_chk #(.NREG(NREG), .W(W), .SEL_W(SEL_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .xfer_en (xfer_en),
  .src_sel (src_sel),
  .dst_sel (dst_sel),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .regs_o  (regs_o),
  .xfer_ld (xfer_ld)
);

// File: tb/reg_xfer_unit_tb_top.sv
module reg_xfer_unit_tb_top;
  localparam int NREG  = 8;
  localparam int W     = 8;
  localparam int SEL_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b0;
  logic              xfer_en = 1'b0;
  logic [SEL_W-1:0]  src_sel = '0;
  logic [SEL_W-1:0]  dst_sel = '0;
  logic              wr_en = 1'b0;
  logic [SEL_W-1:0]  wr_sel = '0;
  logic [W-1:0]      wr_data = '0;
  logic [NREG*W-1:0] regs_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [W-1:0] model [NREG];

  always #10 clk = ~clk; // 50 MHz

  reg_xfer_unit #(.NREG(NREG), .W(W)) dut_i (
    .clk(clk), .rst(rst), .xfer_en(xfer_en), .src_sel(src_sel), .dst_sel(dst_sel),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .regs_o(regs_o)
  );

  // Reference next state computed from the requirements
  function automatic void model_step(bit r, bit x, int s, int d, bit w, int ws, logic [W-1:0] wd);
    logic [W-1:0] old [NREG];
    for (int k = 0; k < NREG; k++) old[k] = model[k];
    if (r) begin
      for (int k = 0; k < NREG; k++) model[k] = '0;
    end else begin
      if (x) model[d] = old[s];
      if (w) model[ws] = wd;
    end
  endfunction

  task automatic check_all(string tag);
    for (int k = 0; k < NREG; k++) begin
      total++;
      if (regs_o[k*W +: W] !== model[k]) begin
        bad++;
        $display("FAIL %s reg%0d actual=%h expected=%h", tag, k, regs_o[k*W +: W], model[k]);
      end
    end
  endtask

  // Called at a falling edge: drive, update model, pass one rising edge, check
  task automatic step(string tag, bit r, bit x, int s, int d, bit w, int ws, logic [W-1:0] wd);
    rst = r; xfer_en = x; src_sel = SEL_W'(s); dst_sel = SEL_W'(d);
    wr_en = w; wr_sel = SEL_W'(ws); wr_data = wd;
    model_step(r, x, s, d, w, ws, wd);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic preload();
    for (int k = 0; k < NREG; k++)
      step("R7", 0, 0, 0, 0, 1, k, W'(8'h11 * (k + 1)));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    for (int k = 0; k < NREG; k++) model[k] = '0;
    @(negedge clk);
    // R1: reset state
    step("R1", 1, 0, 0, 0, 0, 0, '0);
    step("R1", 1, 1, 3, 5, 1, 2, 8'hAA);
    // R7: distinct preload
    preload();
    // R2: plain transfer 3 -> 5; R3/R4 checked by full compare
    step("R2", 0, 1, 3, 5, 0, 0, '0);
    step("R4", 0, 1, 0, 7, 0, 0, '0);
    // R2 with an all-ones/alternating pattern to expose bit lanes
    step("R7", 0, 0, 0, 0, 1, 6, 8'hA5);
    step("R2", 0, 1, 6, 1, 0, 0, '0);
    step("R7", 0, 0, 0, 0, 1, 2, 8'hFF);
    step("R2", 0, 1, 2, 4, 0, 0, '0);
    // R5: selects moving, strobe low
    for (int k = 0; k < NREG; k++) step("R5", 0, 0, k, NREG - 1 - k, 0, 0, '0);
    // R6: same index
    step("R7", 0, 0, 0, 0, 1, 3, 8'h3C);
    step("R6", 0, 1, 3, 3, 0, 0, '0);
    // R8: write and transfer hit the same register
    step("R8", 0, 1, 0, 2, 1, 2, 8'h5A);
    // R9: write into the source while transferring it elsewhere
    step("R9", 0, 1, 1, 6, 1, 1, 8'hC3);
    step("R9", 0, 1, 4, 0, 1, 7, 8'h0F);
    // Random mix
    for (int n = 0; n < 600; n++) begin
      bit x, w;
      x = ($urandom % 4) != 0;
      w = ($urandom % 4) == 0;
      step("R2/R3/R7", 0, x, int'($urandom % NREG), int'($urandom % NREG),
           w, int'($urandom % NREG), W'($urandom));
    end
    // R1: reset in the middle of activity wins
    step("R1", 1, 1, 2, 3, 1, 4, 8'h77);
    step("R3", 0, 0, 0, 0, 0, 0, '0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule